// File: doc/BRIEF.md
# Training-Pattern Bitslip Word Aligner

This block sits behind a deserializer that hands over parallel words of 4 or 8 bits with an unknown bit boundary. The far end transmits a fixed training word over and over. The aligner keeps the last received word and the current one, and picks a WIDTH-bit window out of their concatenation at a slip offset. It compares that window with the expected pattern. After every miss it moves the window by one bit and waits a short settle time. Once the pattern has been seen on enough consecutive words in a row, it declares lock, freezes the offset and presents aligned words.

The active-low `start_ni` input is a synchronous clear for the whole aligner. It should be raised only once the far end is sending the training word. A compile-time option lets the rotated window reach `data_o` while the search is still running. The pattern must be unique under rotation, and no 4-bit nibble of it may be 0x0 or 0xF. Elaboration rejects such a pattern, and it also rejects a width other than 4 or 8.

Top module: `bitslip_word_aligner`

## Requirements
- R1: While `start_ni` is low, each rising edge clears the aligner: `sync_o`, `sweep_miss_o` and `data_o` read 0 after that edge, the slip offset returns to 0 and the stored previous word is cleared.
- R2: Bits arrive MSB first. The candidate is bits [off+WIDTH-1:off] of {previous word, current word}, so offset 0 is the current word itself. The candidate is registered once, and `data_o` shows the registered value.
- R3: After `start_ni` rises, the first comparison takes place on the third rising edge. After each slip, SETTLE_CYCLES edges pass without a comparison. With the defaults, a stream already aligned raises `sync_o` after the 6th edge.
- R4: A comparison that misses advances the offset by one, modulo WIDTH. A stream rotated left by p bits therefore locks 3·p edges later than an aligned one, with the default settle of 2.
- R5: `sync_o` rises only after LOCK_COUNT consecutive matching comparisons. A miss restarts the count.
- R6: Once `sync_o` is high, it stays high and the offset stays frozen whatever data arrives, until `start_ni` goes low.
- R7: With BYPASS = 0, `data_o` is 0 until `sync_o` is high.
- R8: With BYPASS = 1, `data_o` carries the registered candidate even before lock.
- R9: `sweep_miss_o` goes high on the WIDTH-th slip since the last clear. It stays high until `start_ni` is low, and the search keeps cycling through the offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel-word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_ni | input | 1 | Synchronous clear of the aligner, active low |
| data_i | input | WIDTH | Raw word from the deserializer, MSB received first |
| data_o | output | WIDTH | Aligned word (gated by lock unless BYPASS) |
| sync_o | output | 1 | Lock achieved |
| sweep_miss_o | output | 1 | Sticky: a full set of offsets was tried without lock |

## Verification
A wrong offset or a stale previous word shows on `data_o` one edge after it forms: as a rotated copy of the input in bypass mode, or as a rotated copy once lock is reached. A broken settle or match counter moves the edge on which `sync_o` rises by at least one cycle, and a stream at a known phase pins that edge exactly. A slip counter that is off by one moves the rise of `sweep_miss_o` by three cycles. A lost freeze shows within one word of garbage after lock, because `sync_o` drops or `data_o` stops matching the frozen rotation.

// File: rtl/aligner_pkg.sv
`timescale 1ns/1ps
package aligner_pkg;
  // Rejects patterns whose nibbles are all-zero or all-one runs.
  function automatic bit nibbles_legal(logic [7:0] pat, int unsigned w);
    for (int unsigned i = 0; i < w / 4; i++) begin
      if (pat[4*i +: 4] == 4'h0 || pat[4*i +: 4] == 4'hF) return 1'b0;
    end
    return 1'b1;
  endfunction
endpackage

// File: rtl/align_window.sv
`timescale 1ns/1ps
module align_window #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned OFFW = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [OFFW-1:0]  off_i,
  output logic [WIDTH-1:0] cand_o
);
  logic [WIDTH-1:0]   prev_q;
  logic [WIDTH-1:0]   cand_q;
  logic [2*WIDTH-1:0] pair;
  logic [WIDTH-1:0]   win [WIDTH];

  assign pair = {prev_q, data_i};

  for (genvar g = 0; g < WIDTH; g++) begin : g_win
    assign win[g] = pair[g +: WIDTH];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cand_q <= '0;
    end else if (clear_i) begin
      prev_q <= '0;
      cand_q <= '0;
    end else begin
      prev_q <= data_i;
      cand_q <= win[off_i];
    end
  end

  assign cand_o = cand_q;

  AST_WIN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cand_o == '0); // R1
  AST_WIN_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && off_i == '0) |=> cand_o == $past(data_i)); // R2
endmodule

// File: rtl/align_ctrl.sv
`timescale 1ns/1ps
module align_ctrl #(
  parameter int unsigned WIDTH         = 8,
  parameter int unsigned LOCK_COUNT    = 4,
  parameter int unsigned SETTLE_CYCLES = 2,
  localparam int unsigned OFFW = $clog2(WIDTH),
  localparam int unsigned SETW = $clog2(SETTLE_CYCLES + 1),
  localparam int unsigned HITW = $clog2(LOCK_COUNT)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            match_i,
  output logic [OFFW-1:0] off_o,
  output logic            sync_o,
  output logic            slip_o
);
  localparam logic [OFFW-1:0] OFF_MAX  = OFFW'(WIDTH - 1);
  localparam logic [SETW-1:0] SET_INIT = SETW'(SETTLE_CYCLES);
  localparam logic [HITW-1:0] HIT_LAST = HITW'(LOCK_COUNT - 1);

  logic [OFFW-1:0] off_q;
  logic [SETW-1:0] settle_q;
  logic [HITW-1:0] hits_q;
  logic            sync_q;
  logic            cmp_now;

  assign cmp_now = !clear_i && !sync_q && (settle_q == '0);
  assign slip_o  = cmp_now && !match_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q    <= '0;
      settle_q <= SET_INIT;
      hits_q   <= '0;
      sync_q   <= 1'b0;
    end else if (clear_i) begin
      off_q    <= '0;
      settle_q <= SET_INIT;
      hits_q   <= '0;
      sync_q   <= 1'b0;
    end else if (!sync_q) begin
      if (settle_q != '0) begin
        settle_q <= settle_q - 1'b1;
      end else if (match_i) begin
        if (hits_q == HIT_LAST) sync_q <= 1'b1;
        else                    hits_q <= hits_q + 1'b1;
      end else begin
        hits_q   <= '0;
        off_q    <= (off_q == OFF_MAX) ? '0 : off_q + 1'b1;
        settle_q <= SET_INIT;
      end
    end
  end

  assign off_o  = off_q;
  assign sync_o = sync_q;

  AST_CLEAR_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (off_o == '0 && !sync_o)); // R1
  AST_SETTLE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |=> !slip_o); // R3
  AST_SLIP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slip_o && $past(off_o) != OFF_MAX) |=> off_o != $past(off_o, 2)); // R4
  AST_LOCK_NEEDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(match_i)); // R5
  AST_SYNC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && !clear_i) |=> (sync_o && $stable(off_o))); // R6
endmodule

// File: rtl/align_sweep.sv
`timescale 1ns/1ps
module align_sweep #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CNTW = $clog2(WIDTH)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic slip_i,
  output logic miss_o
);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(WIDTH - 1);

  logic [CNTW-1:0] cnt_q;
  logic            miss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      miss_q <= 1'b0;
    end else if (slip_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q  <= '0;
        miss_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign miss_o = miss_q;

  AST_MISS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_o && !clear_i) |=> miss_o); // R9
  AST_MISS_NEEDS_SLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(miss_o) |-> $past(slip_i)); // R9
endmodule

// File: rtl/bitslip_word_aligner.sv
`timescale 1ns/1ps
module bitslip_word_aligner #(
  parameter int unsigned      WIDTH         = 8,
  parameter logic [WIDTH-1:0] PATTERN       = 'h5A,
  parameter int unsigned      LOCK_COUNT    = 4,
  parameter int unsigned      SETTLE_CYCLES = 2,
  parameter bit               BYPASS        = 1'b0,
  localparam int unsigned     OFFW = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o,
  output logic             sync_o,
  output logic             sweep_miss_o
);
  import aligner_pkg::*;

  localparam logic [7:0] PAT8 = 8'(PATTERN);

  if (WIDTH != 4 && WIDTH != 8) begin : g_bad_width
    $error("aligner width must be 4 or 8");
  end
  if (!nibbles_legal(PAT8, WIDTH)) begin : g_bad_pattern
    $error("training pattern has a 0x0 or 0xF nibble");
  end
  if (SETTLE_CYCLES < 2 || LOCK_COUNT < 2) begin : g_bad_timing
    $error("settle and lock counts must be at least 2");
  end

  logic             clear;
  logic [WIDTH-1:0] cand;
  logic [OFFW-1:0]  off;
  logic             match;
  logic             slip;
  logic             sync;

  assign clear = !start_ni;
  assign match = (cand == PATTERN);

  align_window #(.WIDTH(WIDTH)) u_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .data_i (data_i),
    .off_i  (off),
    .cand_o (cand)
  );

  align_ctrl #(
    .WIDTH        (WIDTH),
    .LOCK_COUNT   (LOCK_COUNT),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .match_i(match),
    .off_o  (off),
    .sync_o (sync),
    .slip_o (slip)
  );

  align_sweep #(.WIDTH(WIDTH)) u_sweep (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .slip_i (slip),
    .miss_o (sweep_miss_o)
  );

  if (BYPASS) begin : g_bypass
    assign data_o = cand;
  end else begin : g_gated
    assign data_o = sync ? cand : '0;
  end
  assign sync_o = sync;

  AST_OUT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> data_o == PATTERN); // R2
  AST_GATED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!BYPASS && $fell(sync_o)) |-> data_o == '0); // R7
endmodule

// File: tb/bitslip_word_aligner_test.sv
`timescale 1ns/1ps
module aligner_model #(
  parameter int unsigned  W      = 8,
  parameter logic [W-1:0] PAT    = '0,
  parameter int           LOCK   = 4,
  parameter int           SETTLE = 2,
  parameter bit           BYP    = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] exp_data,
  output logic         exp_sync,
  output logic         exp_miss
);
  int off, wait_c, hits, slips;
  bit locked, swept;
  logic [W-1:0]   prev, cand, nxt;
  logic [2*W-1:0] pair, sh;

  always @(posedge clk) begin
    if (!rst_n || !start_n) begin
      off = 0; wait_c = SETTLE; hits = 0; slips = 0;
      locked = 0; swept = 0; prev = '0; cand = '0;
    end else begin
      pair = {prev, din};
      sh   = pair >> off;
      nxt  = sh[W-1:0];
      if (!locked) begin
        if (wait_c > 0) wait_c--;
        else if (cand == PAT) begin
          hits++;
          if (hits == LOCK) locked = 1;
        end else begin
          hits = 0; off = (off + 1) % W; wait_c = SETTLE; slips++;
          if (slips == W) begin swept = 1; slips = 0; end
        end
      end
      cand = nxt;
      prev = din;
    end
    exp_sync = locked;
    exp_miss = swept;
    exp_data = (BYP || locked) ? cand : '0;
  end
endmodule

module bitslip_word_aligner_test;
  logic clk = 0, rst_n = 0, start_n = 0;
  logic [7:0] d8 = '0, q8, m8_data;
  logic [3:0] d4 = '0, q4, m4_data;
  logic s8, s4, w8, w4, m8_sync, m4_sync, m8_miss, m4_miss;
  int checks = 0, fails = 0;
  bit cmp_on = 0, done = 0;

  always #2 clk = ~clk;

  bitslip_word_aligner #(.WIDTH(8), .PATTERN(8'h5A), .BYPASS(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_ni(start_n), .data_i(d8),
    .data_o(q8), .sync_o(s8), .sweep_miss_o(w8));
  bitslip_word_aligner #(.WIDTH(4), .PATTERN(4'h6), .BYPASS(1'b1)) uut_byp (
    .clk_i(clk), .rst_ni(rst_n), .start_ni(start_n), .data_i(d4),
    .data_o(q4), .sync_o(s4), .sweep_miss_o(w4));

  aligner_model #(.W(8), .PAT(8'h5A), .BYP(1'b0)) ref8 (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .din(d8),
    .exp_data(m8_data), .exp_sync(m8_sync), .exp_miss(m8_miss));
  aligner_model #(.W(4), .PAT(4'h6), .BYP(1'b1)) ref4 (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .din(d4),
    .exp_data(m4_data), .exp_sync(m4_sync), .exp_miss(m4_miss));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R2 w8 data", q8, m8_data);
    chk("R5 w8 sync", 8'(s8), 8'(m8_sync));
    chk("R9 w8 sweep", 8'(w8), 8'(m8_miss));
    chk("R8 w4 data", 8'(q4), 8'(m4_data));
    chk("R5 w4 sync", 8'(s4), 8'(m4_sync));
    chk("R9 w4 sweep", 8'(w4), 8'(m4_miss));
  end

  function automatic logic [7:0] rotl8(logic [7:0] v, int p);
    logic [15:0] t = {v, v} << p;
    return t[15:8];
  endfunction

  task automatic restart(logic [7:0] w8v, logic [3:0] w4v);
    @(negedge clk) start_n = 0;
    @(negedge clk);
    chk("R1 sync clear", 8'(s8), 8'h00);
    chk("R1 sweep clear", 8'(w8), 8'h00);
    chk("R1 data clear", 8'(q4), 8'h00);
    d8 = w8v; d4 = w4v;
    @(negedge clk) start_n = 1;
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset data", q8, 8'h00);
    chk("R1 reset sync", 8'(s8), 8'h00);
    chk("R1 reset sweep", 8'(w8), 8'h00);
    cmp_on = 1;

    // Aligned stream: lock on edge 6
    restart(8'h5A, 4'hC);
    cnt = 0;
    while (!s8 && cnt < 100) begin
      @(negedge clk); cnt++;
      if (cnt == 3) chk("R8 bypass before lock", 8'(q4), 8'h0C);
      if (cnt == 4) chk("R7 gated before lock", q8, 8'h00);
    end
    chk("R3 edges to lock", 8'(cnt), 8'd6);
    chk("R2 aligned word", q8, 8'h5A);
    repeat (6) @(negedge clk);
    chk("R8 bypass locked word", 8'(q4), 8'h06);

    // Stream rotated by 3: three slips
    restart(rotl8(8'h5A, 3), 4'h6);
    cnt = 0;
    while (!s8 && cnt < 100) begin @(negedge clk); cnt++; end
    chk("R4 edges to lock at phase 3", 8'(cnt), 8'd15);
    d8 = 8'h33;
    repeat (10) @(negedge clk);
    chk("R6 sync held", 8'(s8), 8'h01);
    chk("R6 frozen offset", q8, 8'h66);

    // Garbage: full sweep then lock
    restart(8'h33, 4'h5);
    cnt = 0;
    repeat (23) begin @(negedge clk); cnt++; end
    chk("R9 no sweep yet", 8'(w8), 8'h00);
    @(negedge clk);
    chk("R9 sweep flagged", 8'(w8), 8'h01);
    d8 = rotl8(8'h5A, 5); d4 = 4'h3;
    repeat (40) @(negedge clk);
    chk("R4 lock after wrap", 8'(s8), 8'h01);
    chk("R9 sweep sticky", 8'(w8), 8'h01);

    // Broken run of matches restarts the count
    restart(8'h5A, 4'h6);
    cnt = 0;
    repeat (3) begin @(negedge clk); cnt++; end
    d8 = 8'h33;
    @(negedge clk); d8 = 8'h5A;
    repeat (4) @(negedge clk);
    chk("R5 no lock after broken run", 8'(s8), 8'h00);
    repeat (60) @(negedge clk);
    chk("R5 lock after recovery", 8'(s8), 8'h01);

    @(negedge clk) start_n = 0;
    @(negedge clk);
    chk("R1 final clear sync", 8'(s8), 8'h00);
    chk("R1 final clear data", q8, 8'h00);
    cmp_on = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule